// File: doc/BRIEF.md
# Interrupt Distributor Enable/Pending Bank

This block holds the enable and pending state of every interrupt line in a multi-CPU interrupt distributor. Software changes that state through byte writes into four write-one windows: one each to set and to clear enables, and one each to set and to clear pending bits. Every byte covers eight consecutive interrupt numbers. Bit i of the byte acts on its own interrupt and uses that interrupt's own routing.

Interrupts 0 to 31 are internal and banked, so each CPU holds its own enable copy. Interrupts 0 to 15 can never be disabled. Interrupts 32 and above are shared. Their enable is common to all CPUs, and a per-interrupt CPU target mask routes them. The block also watches per-line input levels. An edge-sensitive line goes pending on a rising edge while enabled. Enabling a level-sensitive line whose input is already high makes it pending at once. The outputs are one pending-and-enabled vector per CPU and a one-cycle error pulse for writes that are rejected.

Top module: `irq_dist_bank`

## Requirements
- R1: The byte offset is `wr_addr_i` (10 bits). Offsets 0x100-0x17F set enables, 0x180-0x1FF clear enables, 0x200-0x27F set pending and 0x280-0x2FF clear pending. Interrupt number = (offset - window base) * 8 + i for data bit i. Only bits written as 1 act. Offsets 0x000-0x0FF change nothing and raise no error. State changes are visible from the cycle after the strobe edge.
- R2: A set-enable on interrupts 16-31 enables only the writing CPU's copy. On interrupts 32 and above it enables the line for every CPU.
- R3: Interrupts 0-15 leave reset enabled for every CPU. A set-enable write covering them acts as if all eight data bits were 1. A clear-enable write leaves them enabled.
- R4: A clear-enable on interrupts 16-31 disables only the writing CPU's copy. On 32 and above it disables the line for every CPU.
- R5: When a set-enable acts on an interrupt whose `trig_i` bit is 0 (level) and whose `level_i` bit is 1, that interrupt also becomes pending. For an internal interrupt it goes pending for the writing CPU. For a shared one it goes pending for the CPUs in its target mask.
- R6: A set-pending write marks each selected interrupt pending. A shared interrupt n goes to the CPUs set in `tgt_i[n*NUM_CPU +: NUM_CPU]`, which is its own mask. An internal interrupt goes to the writing CPU.
- R7: A clear-pending write clears the selected interrupts for all CPUs. A pending set arriving in the same cycle wins.
- R8: A write into 0x100-0x2FF whose base interrupt number is NUM_IRQ or more changes no state. It raises `err_o` for exactly one cycle, in the cycle after the strobe.
- R9: A write into 0x300-0x3FF changes no state and raises `err_o` the same way.
- R10: When `trig_i[n]` is 1 (edge), a rising edge of `level_i[n]` makes n pending for each CPU that has n enabled. For shared lines this is further restricted to the target mask. With no edge, or with the line disabled, nothing happens.
- R11: `pend_o[c*NUM_IRQ + n]` is 1 exactly when interrupt n is both pending and enabled for CPU c.
- R12: After reset nothing is pending, `err_o` is 0, and only interrupts 0-15 are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wr_addr_i | input | 10 | Byte offset |
| wr_data_i | input | 8 | Write data, one bit per interrupt |
| wr_cpu_i | input | $clog2(NUM_CPU) | Writing CPU |
| level_i | input | NUM_IRQ | Interrupt input levels |
| trig_i | input | NUM_IRQ | 1 = edge-sensitive, 0 = level-sensitive |
| tgt_i | input | NUM_IRQ*NUM_CPU | Target mask per interrupt, NUM_CPU bits each |
| pend_o | output | NUM_CPU*NUM_IRQ | Pending and enabled, per CPU |
| err_o | output | 1 | Rejected write pulse |

## Verification
Every result of a write or of an input edge is registered once. The bench reference model therefore advances on the same rising edge as the design, and it compares `pend_o` and `err_o` against it on the following falling edge. This is one cycle after the strobe or edge is sampled. Enable state has no output of its own, so it is observed through `pend_o`, after a set-pending write has made the affected lines visible. Directed checks on single output bits pin down the target routing independently of the model.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W     = 10;
  localparam int IDX_W      = 7;
  localparam int FORCED_IRQ = 16;
  localparam int BANKED_IRQ = 32;

  typedef enum logic [2:0] {
    WIN_RSVD0  = 3'd0,
    WIN_RSVD1  = 3'd1,
    WIN_EN_SET = 3'd2,
    WIN_EN_CLR = 3'd3,
    WIN_PD_SET = 3'd4,
    WIN_PD_CLR = 3'd5,
    WIN_ACT0   = 3'd6,
    WIN_ACT1   = 3'd7
  } win_e;
endpackage

// File: rtl/irqd_wr_decode.sv
module irqd_wr_decode
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int NUM_BYTE = NUM_IRQ / 8,
  localparam int VEC_W  = NUM_CPU * NUM_IRQ
) (
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  input  logic [CPU_W-1:0]           wr_cpu_i,
  input  logic [NUM_IRQ-1:0]         level_i,
  input  logic [NUM_IRQ-1:0]         trig_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0] tgt_i,
  output logic [VEC_W-1:0]           en_set_o,
  output logic [VEC_W-1:0]           en_clr_o,
  output logic [VEC_W-1:0]           pd_set_o,
  output logic [VEC_W-1:0]           pd_clr_o,
  output logic                       bad_o
);
  win_e             win;
  logic [IDX_W-1:0] idx;
  logic             idx_ok, live;

  always_comb begin
    win    = win_e'(wr_addr_i[ADDR_W-1:IDX_W]);
    idx    = wr_addr_i[IDX_W-1:0];
    idx_ok = int'(idx) < NUM_BYTE;
    live   = wr_i && idx_ok;
    bad_o  = wr_i && ((win == WIN_ACT0) || (win == WIN_ACT1) ||
                      ((win inside {WIN_EN_SET, WIN_EN_CLR, WIN_PD_SET, WIN_PD_CLR}) && !idx_ok));
  end

  always_comb begin
    en_set_o = '0;
    en_clr_o = '0;
    pd_set_o = '0;
    pd_clr_o = '0;
    for (int n = 0; n < NUM_IRQ; n++) begin
      logic in_byte, hit, se, intl;
      in_byte = live && ((n / 8) == int'(idx));
      hit     = in_byte && wr_data_i[n % 8];
      intl    = n < BANKED_IRQ;
      se      = in_byte && (win == WIN_EN_SET) && (wr_data_i[n % 8] || (n < FORCED_IRQ));
      for (int c = 0; c < NUM_CPU; c++) begin
        logic mine, bank, route;
        mine  = c == int'(wr_cpu_i);
        bank  = intl ? mine : 1'b1;
        route = intl ? mine : tgt_i[n*NUM_CPU + c];
        en_set_o[c*NUM_IRQ + n] = se && bank;
        en_clr_o[c*NUM_IRQ + n] = hit && (win == WIN_EN_CLR) && (n >= FORCED_IRQ) && bank;
        // enabling a high level line pends it
        pd_set_o[c*NUM_IRQ + n] = route && ((se && !trig_i[n] && level_i[n]) ||
                                            (hit && (win == WIN_PD_SET)));
        pd_clr_o[c*NUM_IRQ + n] = hit && (win == WIN_PD_CLR);
      end
    end
  end
endmodule

// File: rtl/irqd_edge_det.sv
module irqd_edge_det #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] level_i,
  output logic [NUM_IRQ-1:0] rise_o
);
  logic [NUM_IRQ-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int VEC_W  = NUM_CPU * NUM_IRQ
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  input  logic [CPU_W-1:0]           wr_cpu_i,
  input  logic [NUM_IRQ-1:0]         level_i,
  input  logic [NUM_IRQ-1:0]         trig_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0] tgt_i,
  output logic [VEC_W-1:0]           pend_o,
  output logic                       err_o
);
  function automatic logic [VEC_W-1:0] rst_en_f();
    logic [VEC_W-1:0] v;
    v = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int n = 0; n < FORCED_IRQ; n++) v[c*NUM_IRQ + n] = 1'b1;
    return v;
  endfunction

  localparam logic [VEC_W-1:0] RST_EN = rst_en_f();

  logic [VEC_W-1:0]   en_q, pd_q;
  logic [VEC_W-1:0]   en_set, en_clr, pd_set, pd_clr, pd_edge;
  logic [NUM_IRQ-1:0] rise;
  logic               bad, err_q;

  irqd_wr_decode #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) i_dec (
    .wr_i     (wr_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wr_cpu_i (wr_cpu_i),
    .level_i  (level_i),
    .trig_i   (trig_i),
    .tgt_i    (tgt_i),
    .en_set_o (en_set),
    .en_clr_o (en_clr),
    .pd_set_o (pd_set),
    .pd_clr_o (pd_clr),
    .bad_o    (bad)
  );

  irqd_edge_det #(.NUM_IRQ(NUM_IRQ)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_i),
    .rise_o (rise)
  );

  always_comb begin
    pd_edge = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int n = 0; n < NUM_IRQ; n++)
        pd_edge[c*NUM_IRQ + n] = rise[n] && trig_i[n] && en_q[c*NUM_IRQ + n] &&
                                 ((n < BANKED_IRQ) || tgt_i[n*NUM_CPU + c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= RST_EN;
      pd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      en_q  <= (en_q & ~en_clr) | en_set;
      pd_q  <= (pd_q & ~pd_clr) | pd_set | pd_edge;  // set wins over clear
      err_q <= bad;
    end
  end

  assign pend_o = pd_q & en_q;
  assign err_o  = err_q;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int VEC_W  = NUM_CPU * NUM_IRQ
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              err_o,
  input logic [VEC_W-1:0]  en_q
);
  logic low_on, shared_eq;

  always_comb begin
    low_on    = 1'b1;
    shared_eq = 1'b1;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int n = 0; n < FORCED_IRQ; n++)
        if (!en_q[c*NUM_IRQ + n]) low_on = 1'b0;
      for (int n = BANKED_IRQ; n < NUM_IRQ; n++)
        if (en_q[c*NUM_IRQ + n] != en_q[n]) shared_eq = 1'b0;
    end
  end

  assert_err_after_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i));

  assert_bad_keeps_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (en_q == $past(en_q)));

  assert_active_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (wr_addr_i[ADDR_W-1:ADDR_W-2] == 2'b11)) |=> err_o);

  assert_low_forced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_on);

  assert_shared_common_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_eq);
endmodule

bind irq_dist_bank irqd_checker #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .wr_addr_i(wr_addr_i),
  .err_o    (err_o),
  .en_q     (en_q)
);

// File: tb/test_irq_dist_bank.sv
`timescale 1ns/1ps
module test_irq_dist_bank;
  localparam int NC = 4;
  localparam int NI = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [9:0]        addr = '0;
  logic [7:0]        data = '0;
  logic [1:0]        cpu = '0;
  logic [NI-1:0]     lvl = '0;
  logic [NI-1:0]     trig;
  logic [NI*NC-1:0]  tgt;
  logic [NC*NI-1:0]  pend;
  logic              err;

  int checks = 0;
  int errors = 0;
  string cur_req = "R12";
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_dist_bank #(.NUM_CPU(NC), .NUM_IRQ(NI)) i_irq_dist_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(addr), .wr_data_i(data),
    .wr_cpu_i(cpu), .level_i(lvl), .trig_i(trig), .tgt_i(tgt),
    .pend_o(pend), .err_o(err)
  );

  function automatic logic [3:0] tgt_of(int n);
    logic [3:0] v;
    v = 4'((n * 7 + 1) & 15);
    if (v == 4'd0) v = 4'd1;
    return v;
  endfunction

  initial begin
    for (int n = 0; n < NI; n++) begin
      trig[n] = n[0];  // odd lines edge-sensitive
      tgt[n*NC +: NC] = tgt_of(n);
    end
  end

  // behavioural reference model
  bit m_en [NC][NI];
  bit m_pd [NC][NI];
  bit m_prev [NI];
  bit m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++)
        for (int n = 0; n < NI; n++) begin
          m_en[c][n] = (n < 16);
          m_pd[c][n] = 1'b0;
        end
      for (int n = 0; n < NI; n++) m_prev[n] = 1'b0;
      m_err = 1'b0;
    end else begin
      bit nen [NC][NI];
      bit npd [NC][NI];
      int win, base;
      nen = m_en;
      npd = m_pd;
      win = int'(addr) / 128;
      base = (int'(addr) % 128) * 8;
      m_err = 1'b0;
      if (wr) begin
        if (win >= 6 || (win >= 2 && base >= NI)) m_err = 1'b1;
        else if (win >= 2) begin
          for (int i = 0; i < 8; i++) begin
            int n;
            bit b;
            n = base + i;
            b = data[i];
            for (int c = 0; c < NC; c++) begin
              bit own, rt;
              own = (c == int'(cpu));
              rt  = (n < 32) ? own : tgt[n*NC + c];
              case (win)
                2: if (b || n < 16) begin
                     if (n >= 32 || own) nen[c][n] = 1'b1;
                     if (!trig[n] && lvl[n] && rt) npd[c][n] = 1'b1;
                   end
                3: if (b && n >= 16 && (n >= 32 || own)) nen[c][n] = 1'b0;
                4: if (b && rt) npd[c][n] = 1'b1;
                5: if (b) npd[c][n] = 1'b0;
                default: ;
              endcase
            end
          end
        end
      end
      for (int n = 0; n < NI; n++)
        if (trig[n] && lvl[n] && !m_prev[n])
          for (int c = 0; c < NC; c++)
            if (m_en[c][n] && (n < 32 || tgt[n*NC + c])) npd[c][n] = 1'b1;
      for (int n = 0; n < NI; n++) m_prev[n] = lvl[n];
      m_en = nen;
      m_pd = npd;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NC*NI-1:0] exp_v;
      for (int c = 0; c < NC; c++)
        for (int n = 0; n < NI; n++) exp_v[c*NI + n] = m_pd[c][n] & m_en[c][n];
      checks++;
      if (pend !== exp_v || err !== m_err) begin
        errors++;
        $display("FAIL %s: pend_o=%h err_o=%b expected pend=%h err=%b",
                 cur_req, pend, err, exp_v, m_err);
      end
    end
  end

  task automatic do_wr(input logic [9:0] a, input logic [7:0] d, input logic [1:0] c);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d; cpu = c;
    @(negedge clk);
    wr = 1'b0; addr = '0; data = '0;
  endtask

  task automatic chk_bit(input string req, input int idx, input logic exp_b);
    checks++;
    if (pend[idx] !== exp_b) begin
      errors++;
      $display("FAIL %s: pend_o[%0d]=%b expected %b", req, idx, pend[idx], exp_b);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R12";
    checks++;
    if (pend !== '0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R12: pend_o=%h err_o=%b expected 0 0", pend, err);
    end

    cur_req = "R6";
    do_wr(10'h205, 8'hFF, 2'd1);  // irq 40-47 pending, not yet enabled
    idle(1);
    chk_bit("R11", 2*NI + 45, 1'b0);
    cur_req = "R1";
    do_wr(10'h105, 8'hA5, 2'd0);  // enable 40,42,45,47 shared
    idle(1);
    chk_bit("R6", 2*NI + 45, 1'b1);  // tgt(45)=1100
    chk_bit("R6", 0*NI + 45, 1'b0);
    chk_bit("R2", 3*NI + 47, tgt_of(47)[3]);
    chk_bit("R1", 2*NI + 41, 1'b0);

    cur_req = "R4";
    do_wr(10'h185, 8'h05, 2'd3);
    idle(1);

    cur_req = "R2";
    do_wr(10'h102, 8'h0F, 2'd2);  // 16-19 for cpu2 only
    do_wr(10'h202, 8'hFF, 2'd2);
    do_wr(10'h202, 8'hFF, 2'd1);
    idle(1);
    chk_bit("R2", 2*NI + 17, 1'b1);
    chk_bit("R2", 1*NI + 17, 1'b0);
    cur_req = "R4";
    do_wr(10'h182, 8'h01, 2'd1);  // cpu1 copy only
    idle(1);
    chk_bit("R4", 2*NI + 16, 1'b1);

    cur_req = "R3";
    do_wr(10'h180, 8'hFF, 2'd0);
    do_wr(10'h200, 8'hFF, 2'd0);
    do_wr(10'h100, 8'h00, 2'd1);
    idle(1);
    chk_bit("R3", 0*NI + 3, 1'b1);

    cur_req = "R5";
    lvl[48] = 1'b1; lvl[18] = 1'b1;
    idle(2);
    do_wr(10'h106, 8'h01, 2'd1);
    do_wr(10'h102, 8'h04, 2'd3);
    idle(1);
    chk_bit("R5", 3*NI + 18, 1'b1);
    chk_bit("R5", 1*NI + 18, 1'b0);

    cur_req = "R7";
    do_wr(10'h285, 8'hFF, 2'd2);
    idle(1);
    chk_bit("R7", 2*NI + 45, 1'b0);

    cur_req = "R10";
    @(negedge clk);
    lvl[45] = 1'b1; lvl[41] = 1'b1; lvl[17] = 1'b1;
    idle(2);
    chk_bit("R10", 3*NI + 45, 1'b1);
    chk_bit("R10", 2*NI + 41, 1'b0);
    chk_bit("R10", 2*NI + 17, 1'b1);
    lvl[45] = 1'b0;
    idle(2);

    cur_req = "R7";
    do_wr(10'h282, 8'hFF, 2'd0);
    idle(1);

    cur_req = "R8";
    do_wr(10'h108, 8'hFF, 2'd0);
    do_wr(10'h27F, 8'hFF, 2'd1);
    cur_req = "R9";
    do_wr(10'h300, 8'hFF, 2'd0);
    do_wr(10'h3FF, 8'hFF, 2'd2);
    cur_req = "R1";
    do_wr(10'h050, 8'hFF, 2'd0);
    idle(2);

    cur_req = "R7";  // clear and edge set in one cycle: set wins
    @(negedge clk);
    wr = 1'b1; addr = 10'h285; data = 8'h20; cpu = 2'd0; lvl[45] = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = '0; data = '0;
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule